// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a 36-bit first-in first-out buffer whose writer and reader run on unrelated clocks. Each side makes an access by raising an enable and a request together; the side grants the access with an acknowledge only when it cannot overflow or underflow. The grant is decided from the side's own pointer and a synchronized copy of the other side's pointer. Because of this, the buffer can run right up to its full and empty boundaries with no external arbitration.

The write side reports full, almost-full and half-full. The read side reports almost-empty and empty. The two near-boundary thresholds are offsets that each side loads through its own small configuration port. Each flag has a mode bit. With the bit set, the flag is registered to its port clock. With the bit clear, the flag follows the pointer comparison directly.

A replay facility lets the reader hold a block of words. The reader can then rewind to the start of that block and read it again any number of times. The held words stay reserved against the writer until the hold is dropped.

Top module: `dcfifo_pf`

## Requirements
- R1: After reset: empty and almost-empty are 1; full, almost-full, half-full and both acknowledges are 0; rd_data is 0. Both offsets are 8 and every flag mode bit is 1 (registered).
- R2: A write happens on a wr_clk rising edge where wr_en and wr_req are both 1 and the buffer is not full. wr_ack is then 1 for exactly the following cycle. With either input low, no word is stored and wr_ack stays 0.
- R3: At an occupancy of DEPTH, a write request gets no wr_ack and stores nothing. The stored words read back unchanged, and neither side ever sees an occupancy above DEPTH.
- R4: A read happens on an rd_clk rising edge where rd_en and rd_req are both 1 and the buffer is not empty. rd_ack is 1 and rd_data holds the word for the following cycle, and words leave in write order. A read request on an empty buffer gets no rd_ack.
- R5: The write pointer crosses to the read side as Gray code, changing at most one bit per cycle, through two flops. A word written at wr edge N clears the empty comparison after rd edge N+2.
- R6: full = occupancy equals DEPTH. almost-full = occupancy ≥ DEPTH − write offset. half-full = occupancy ≥ DEPTH/2. almost-empty = read-side occupancy ≤ read offset. empty = read-side occupancy is 0.
- R7: Write mode bits are bit 0 for full, bit 1 for almost-full and bit 2 for half-full. Read mode bits are bit 0 for empty and bit 1 for almost-empty. With a bit at 1, the flag shows the comparison one edge later. With a bit at 0, the flag shows the comparison in the same cycle.
- R8: With a side's cfg_we high at a rising edge, that side's offset and mode bits are loaded. The new values apply to the flags from that edge on.
- R9: While rd_keep is 1, read words are not released to the writer. An rd_rewind edge with rd_keep at 1 returns the read position to the oldest unreleased word and refuses any read on that same edge. An rd_rewind edge with rd_keep at 0 has no effect.
- R10: Released space moves one word per rd_clk edge and crosses as Gray code. A word read at rd edge N is visible to the write-side comparison after wr edge N+3.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write side clock |
| wr_rst_n | input | 1 | Write side synchronous reset, active low |
| wr_en | input | 1 | Write enable |
| wr_req | input | 1 | Write request |
| wr_data | input | WIDTH | Word to store |
| wr_ack | output | 1 | Write granted on the previous edge |
| wr_cfg_we | input | 1 | Load write-side offset and mode bits |
| wr_cfg_off | input | AW+1 | Almost-full offset |
| wr_cfg_sync | input | 3 | Write-side flag mode bits |
| full | output | 1 | Buffer full |
| afull | output | 1 | Almost full |
| hfull | output | 1 | Half full or more |
| rd_clk | input | 1 | Read side clock |
| rd_rst_n | input | 1 | Read side synchronous reset, active low |
| rd_en | input | 1 | Read enable |
| rd_req | input | 1 | Read request |
| rd_keep | input | 1 | Hold read words for replay |
| rd_rewind | input | 1 | Return to start of held block |
| rd_data | output | WIDTH | Word read on the previous edge |
| rd_ack | output | 1 | Read granted on the previous edge |
| rd_cfg_we | input | 1 | Load read-side offset and mode bits |
| rd_cfg_off | input | AW+1 | Almost-empty offset |
| rd_cfg_sync | input | 2 | Read-side flag mode bits |
| empty | output | 1 | Buffer empty |
| aempty | output | 1 | Almost empty |

## Verification
Acknowledges and rd_data are due one edge after the granting edge. A write reaches the read-side comparison two edges later, and a read frees space for the writer three edges later. A registered flag adds one more edge to each of these. The bench runs both ports from one clock so that these edge counts are fixed. It drives inputs at falling edges and samples each result at the falling edge that follows exactly the stated number of rising edges. Where it checks flags in both modes, it checks the cycle before a change as well as the cycle of the change.

// File: rtl/dcf_pkg.sv
// Shared constants for the dual-clock FIFO: reset offset and the
// positions of the per-flag mode bits in each side's configuration word.
package dcf_pkg;
    localparam int DEF_OFFSET = 8;
    // write side mode bit positions
    localparam int MB_FULL    = 0;
    localparam int MB_AFULL   = 1;
    localparam int MB_HFULL   = 2;
    // read side mode bit positions
    localparam int MB_EMPTY   = 0;
    localparam int MB_AEMPTY  = 1;
endpackage

// File: rtl/dcf_sync.sv
// Two-flop synchronizer for a Gray-coded pointer.
// Assumes the source changes at most one bit per source clock.
module dcf_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    // capture then re-register in the destination domain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta <= '0;
            q    <= '0;
        end else begin
            meta <= d;
            q    <= meta;
        end
    end
endmodule

// File: rtl/dcf_wr_side.sv
// Write side: write pointer, grant, configuration and the three fill flags.
// Assumes rel_gray_s is the reader's release pointer, already synchronized,
// and that DEPTH is a power of two.
module dcf_wr_side #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic          wr_req,
    input  logic          cfg_we,
    input  logic [AW:0]   cfg_off,
    input  logic [2:0]    cfg_sync,
    input  logic [AW:0]   rel_gray_s,
    output logic          accept,
    output logic [AW-1:0] waddr,
    output logic          wr_ack,
    output logic [AW:0]   wr_gray,
    output logic          full,
    output logic          afull,
    output logic          hfull
);
    import dcf_pkg::*;
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);
    localparam logic [PW-1:0] HALF_V  = PW'(DEPTH / 2);

    logic [PW-1:0] wptr, wptr_nx, rel_bin, occ, af_off;
    logic [PW:0]   af_sum;
    logic [2:0]    mode;
    logic          full_c, afull_c, hfull_c, full_q, afull_q, hfull_q;

    // Gray to binary of the synchronized release pointer
    always_comb begin
        rel_bin[PW-1] = rel_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            rel_bin[i] = rel_bin[i+1] ^ rel_gray_s[i];
        end
    end

    assign occ     = wptr - rel_bin;
    assign af_sum  = {1'b0, occ} + {1'b0, af_off};
    assign full_c  = (occ == DEPTH_V);
    assign afull_c = (af_sum >= {1'b0, DEPTH_V});
    assign hfull_c = (occ >= HALF_V);
    assign accept  = wr_en & wr_req & ~full_c;
    assign wptr_nx = accept ? wptr + PW'(1) : wptr;
    assign waddr   = wptr[AW-1:0];

    // pointer, grant, config and registered flag copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr    <= '0;
            wr_gray <= '0;
            wr_ack  <= 1'b0;
            af_off  <= PW'(DEF_OFFSET);
            mode    <= '1;
            full_q  <= 1'b0;
            afull_q <= 1'b0;
            hfull_q <= 1'b0;
        end else begin
            wptr    <= wptr_nx;
            wr_gray <= wptr_nx ^ (wptr_nx >> 1);
            wr_ack  <= accept;
            if (cfg_we) begin
                af_off <= cfg_off;
                mode   <= cfg_sync;
            end
            full_q  <= full_c;
            afull_q <= afull_c;
            hfull_q <= hfull_c;
        end
    end

    assign full  = mode[MB_FULL]  ? full_q  : full_c;
    assign afull = mode[MB_AFULL] ? afull_q : afull_c;
    assign hfull = mode[MB_HFULL] ? hfull_q : hfull_c;

    // R3
    wr_occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V);
    // R2
    wr_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |-> $past(wr_en && wr_req));
    // R5
    wr_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(wr_gray ^ $past(wr_gray)) <= 1);
endmodule

// File: rtl/dcf_rd_side.sv
// Read side: read pointer, release pointer for replay, grant, configuration
// and the two drain flags. Assumes wr_gray_s is the synchronized write
// pointer and that rd_keep is raised while the release pointer has caught up.
module dcf_rd_side #(
    parameter int DEPTH = 512,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rd_en,
    input  logic          rd_req,
    input  logic          rd_keep,
    input  logic          rd_rewind,
    input  logic          cfg_we,
    input  logic [AW:0]   cfg_off,
    input  logic [1:0]    cfg_sync,
    input  logic [AW:0]   wr_gray_s,
    output logic          take,
    output logic [AW-1:0] raddr,
    output logic          rd_ack,
    output logic [AW:0]   rel_gray,
    output logic          empty,
    output logic          aempty
);
    import dcf_pkg::*;
    localparam int PW = AW + 1;
    localparam logic [PW-1:0] DEPTH_V = PW'(DEPTH);

    logic [PW-1:0] rptr, rptr_nx, start, start_nx, wbin, occ, ae_off;
    logic [1:0]    mode;
    logic          rewind_act, empty_c, aempty_c, empty_q, aempty_q;

    // Gray to binary of the synchronized write pointer
    always_comb begin
        wbin[PW-1] = wr_gray_s[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            wbin[i] = wbin[i+1] ^ wr_gray_s[i];
        end
    end

    assign occ        = wbin - rptr;
    assign empty_c    = (occ == '0);
    assign aempty_c   = (occ <= ae_off);
    assign rewind_act = rd_rewind & rd_keep;
    assign take       = rd_en & rd_req & ~empty_c & ~rewind_act;
    assign rptr_nx    = rewind_act ? start : (take ? rptr + PW'(1) : rptr);
    // release steps one word per edge so its Gray copy moves one bit at a time
    assign start_nx   = (!rd_keep && (start != rptr)) ? start + PW'(1) : start;
    assign raddr      = rptr[AW-1:0];

    // pointers, grant, config and registered flag copies
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr     <= '0;
            start    <= '0;
            rel_gray <= '0;
            rd_ack   <= 1'b0;
            ae_off   <= PW'(DEF_OFFSET);
            mode     <= '1;
            empty_q  <= 1'b1;
            aempty_q <= 1'b1;
        end else begin
            rptr     <= rptr_nx;
            start    <= start_nx;
            rel_gray <= start_nx ^ (start_nx >> 1);
            rd_ack   <= take;
            if (cfg_we) begin
                ae_off <= cfg_off;
                mode   <= cfg_sync;
            end
            empty_q  <= empty_c;
            aempty_q <= aempty_c;
        end
    end

    assign empty  = mode[MB_EMPTY]  ? empty_q  : empty_c;
    assign aempty = mode[MB_AEMPTY] ? aempty_q : aempty_c;

    // R3
    rd_occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V);
    // R4
    rd_ack_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_ack |-> $past(rd_en && rd_req));
    // R9
    keep_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_keep |=> $stable(rel_gray));
    // R9
    rewind_no_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_rewind && rd_keep) |=> !rd_ack);
    // R10
    rel_gray_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(rel_gray ^ $past(rel_gray)) <= 1);
endmodule

// File: rtl/dcfifo_pf.sv
// Dual-clock FIFO top: storage array, read data register and the two
// pointer crossings between the write and read sides.
// Assumes DEPTH is a power of two and both resets are applied together.
module dcfifo_pf #(
    parameter  int WIDTH = 36,
    parameter  int DEPTH = 512,
    localparam int AW    = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             wr_rst_n,
    input  logic             wr_en,
    input  logic             wr_req,
    input  logic [WIDTH-1:0] wr_data,
    output logic             wr_ack,
    input  logic             wr_cfg_we,
    input  logic [AW:0]      wr_cfg_off,
    input  logic [2:0]       wr_cfg_sync,
    output logic             full,
    output logic             afull,
    output logic             hfull,
    input  logic             rd_clk,
    input  logic             rd_rst_n,
    input  logic             rd_en,
    input  logic             rd_req,
    input  logic             rd_keep,
    input  logic             rd_rewind,
    output logic [WIDTH-1:0] rd_data,
    output logic             rd_ack,
    input  logic             rd_cfg_we,
    input  logic [AW:0]      rd_cfg_off,
    input  logic [1:0]       rd_cfg_sync,
    output logic             empty,
    output logic             aempty
);
    logic [WIDTH-1:0] mem [DEPTH];
    logic             accept, take;
    logic [AW-1:0]    waddr, raddr;
    logic [AW:0]      wr_gray, wr_gray_s, rel_gray, rel_gray_s;

    dcf_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk(wr_clk), .rst_n(wr_rst_n), .wr_en(wr_en), .wr_req(wr_req),
        .cfg_we(wr_cfg_we), .cfg_off(wr_cfg_off), .cfg_sync(wr_cfg_sync),
        .rel_gray_s(rel_gray_s), .accept(accept), .waddr(waddr),
        .wr_ack(wr_ack), .wr_gray(wr_gray), .full(full), .afull(afull),
        .hfull(hfull));

    dcf_rd_side #(.DEPTH(DEPTH), .AW(AW)) u_rd (
        .clk(rd_clk), .rst_n(rd_rst_n), .rd_en(rd_en), .rd_req(rd_req),
        .rd_keep(rd_keep), .rd_rewind(rd_rewind), .cfg_we(rd_cfg_we),
        .cfg_off(rd_cfg_off), .cfg_sync(rd_cfg_sync), .wr_gray_s(wr_gray_s),
        .take(take), .raddr(raddr), .rd_ack(rd_ack), .rel_gray(rel_gray),
        .empty(empty), .aempty(aempty));

    dcf_sync #(.W(AW + 1)) u_w2r (
        .clk(rd_clk), .rst_n(rd_rst_n), .d(wr_gray), .q(wr_gray_s));

    dcf_sync #(.W(AW + 1)) u_r2w (
        .clk(wr_clk), .rst_n(wr_rst_n), .d(rel_gray), .q(rel_gray_s));

    // store a granted word
    always_ff @(posedge wr_clk) begin
        if (accept) begin
            mem[waddr] <= wr_data;
        end
    end

    // register the word leaving on a granted read
    always_ff @(posedge rd_clk) begin
        if (!rd_rst_n) begin
            rd_data <= '0;
        end else if (take) begin
            rd_data <= mem[raddr];
        end
    end
endmodule

// File: tb/test_dcfifo_pf.sv
// Directed bench: both ports share one 50 MHz clock so edge counts are exact.
module test_dcfifo_pf;
    localparam int W = 36;
    localparam int D = 16;
    localparam int A = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic wr_en = 0, wr_req = 0, wr_cfg_we = 0;
    logic [W-1:0] wr_data = '0;
    logic [A:0] wr_cfg_off = '0, rd_cfg_off = '0;
    logic [2:0] wr_cfg_sync = '0;
    logic rd_en = 0, rd_req = 0, rd_keep = 0, rd_rewind = 0, rd_cfg_we = 0;
    logic [1:0] rd_cfg_sync = '0;
    logic wr_ack, full, afull, hfull, rd_ack, empty, aempty;
    logic [W-1:0] rd_data;
    int checks = 0, fails = 0;
    bit done = 0;

    always #10 clk = ~clk;

    dcfifo_pf #(.WIDTH(W), .DEPTH(D)) i_dcfifo_pf (
        .wr_clk(clk), .wr_rst_n(rst_n), .wr_en(wr_en), .wr_req(wr_req),
        .wr_data(wr_data), .wr_ack(wr_ack), .wr_cfg_we(wr_cfg_we),
        .wr_cfg_off(wr_cfg_off), .wr_cfg_sync(wr_cfg_sync), .full(full),
        .afull(afull), .hfull(hfull), .rd_clk(clk), .rd_rst_n(rst_n),
        .rd_en(rd_en), .rd_req(rd_req), .rd_keep(rd_keep),
        .rd_rewind(rd_rewind), .rd_data(rd_data), .rd_ack(rd_ack),
        .rd_cfg_we(rd_cfg_we), .rd_cfg_off(rd_cfg_off),
        .rd_cfg_sync(rd_cfg_sync), .empty(empty), .aempty(aempty));

    task automatic chk(input logic [63:0] act, input logic [63:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic cyc();
        @(negedge clk);
    endtask

    task automatic wr_one(input logic [W-1:0] d);
        wr_en = 1; wr_req = 1; wr_data = d;
        cyc();
        wr_en = 0; wr_req = 0;
    endtask

    task automatic rd_one(input logic [W-1:0] exp, input string tag);
        rd_en = 1; rd_req = 1;
        cyc();
        rd_en = 0; rd_req = 0;
        chk(rd_ack, 1, {tag, " ack"});
        chk(rd_data, exp, {tag, " data"});
    endtask

    task automatic cfg(input logic [A:0] woff, input logic [2:0] wsync,
                       input logic [A:0] roff, input logic [1:0] rsync);
        wr_cfg_we = 1; wr_cfg_off = woff; wr_cfg_sync = wsync;
        rd_cfg_we = 1; rd_cfg_off = roff; rd_cfg_sync = rsync;
        cyc();
        wr_cfg_we = 0; rd_cfg_we = 0;
    endtask

    task automatic t_reset();
        rst_n = 0;
        repeat (3) cyc();
        rst_n = 1;
        cyc();
        chk(empty, 1, "R1 empty");
        chk(aempty, 1, "R1 aempty");
        chk({full, afull, hfull}, 0, "R1 write flags");
        chk({wr_ack, rd_ack}, 0, "R1 acks");
        chk(rd_data, 0, "R1 rd_data");
    endtask

    // default offsets of 8 and registered flags
    task automatic t_defaults();
        for (int i = 0; i < 8; i++) wr_one(W'(i + 1));
        repeat (5) cyc();
        chk(afull, 1, "R1 default afull offset");
        chk(hfull, 1, "R6 hfull at D/2");
        chk(aempty, 1, "R1 default aempty offset");
        wr_one(W'(9));
        repeat (5) cyc();
        chk(aempty, 0, "R6 aempty above offset");
        chk(full, 0, "R6 not full");
        for (int i = 0; i < 9; i++) rd_one(W'(i + 1), "R4 order");
        repeat (5) cyc();
        chk(empty, 1, "R4 drained");
        chk(hfull, 0, "R6 hfull clear");
    endtask

    task automatic t_enreq();
        wr_en = 1; wr_req = 0;
        cyc();
        chk(wr_ack, 0, "R2 enable only");
        wr_en = 0; wr_req = 1;
        cyc();
        chk(wr_ack, 0, "R2 request only");
        wr_req = 0;
        repeat (4) cyc();
        chk(empty, 1, "R2 nothing stored");
        rd_en = 1; rd_req = 1;
        cyc();
        rd_en = 0; rd_req = 0;
        chk(rd_ack, 0, "R4 empty read refused");
    endtask

    task automatic t_latency();
        wr_one(W'(36'hA5A5));
        chk(wr_ack, 1, "R2 ack");
        chk(empty, 1, "R5 after E0");
        cyc();
        chk(wr_ack, 0, "R2 ack one cycle");
        chk(empty, 1, "R5 after E1");
        cyc();
        chk(empty, 1, "R7 registered empty lags");
        cyc();
        chk(empty, 0, "R5 registered empty after E3");
        rd_one(W'(36'hA5A5), "R4 single");
        chk(empty, 0, "R7 registered empty still low");
        cyc();
        chk(empty, 1, "R7 registered empty set");
        cfg(5'd8, 3'b111, 5'd8, 2'b00);
        wr_one(W'(36'h5A5A));
        cyc();
        chk(empty, 1, "R5 direct empty after E1");
        cyc();
        chk(empty, 0, "R5 direct empty after E2");
        rd_one(W'(36'h5A5A), "R4 single direct");
        chk(empty, 1, "R7 direct empty same cycle");
    endtask

    task automatic t_full();
        int wocc;
        cfg(5'd3, 3'b000, 5'd2, 2'b00);
        repeat (4) cyc();
        for (int k = 1; k <= 16; k++) begin
            wr_one(W'(100 + k));
            chk(full, (k == 16), "R3 full");
            chk(afull, (k >= 13), "R8 afull with offset 3");
            chk(hfull, (k >= 8), "R6 hfull");
        end
        wr_en = 1; wr_req = 1; wr_data = W'(36'hBAD);
        cyc();
        wr_en = 0; wr_req = 0;
        chk(wr_ack, 0, "R3 write refused when full");
        chk(full, 1, "R3 still full");
        repeat (3) cyc();
        chk(empty, 0, "R6 not empty");
        chk(aempty, 0, "R8 aempty offset 2");
        for (int j = 1; j <= 16; j++) begin
            rd_one(W'(100 + j), "R3 contents intact");
            wocc = 16 - ((j > 3) ? j - 3 : 0);
            chk(full, (wocc == 16), "R10 release latency full");
            chk(afull, (wocc >= 13), "R10 release latency afull");
            chk(aempty, ((16 - j) <= 2), "R8 aempty");
            chk(empty, (j == 16), "R6 empty");
        end
        repeat (5) cyc();
        chk({full, afull, hfull}, 0, "R10 all space released");
    endtask

    task automatic t_retx();
        cfg(5'd12, 3'b000, 5'd2, 2'b00);
        rd_keep = 1;
        cyc();
        for (int i = 0; i < 4; i++) wr_one(W'(200 + i));
        repeat (3) cyc();
        chk(afull, 1, "R8 afull with offset 12");
        for (int i = 0; i < 4; i++) rd_one(W'(200 + i), "R9 first pass");
        repeat (5) cyc();
        chk(empty, 1, "R9 block read");
        chk(afull, 1, "R9 space held while keep");
        for (int p = 0; p < 2; p++) begin
            rd_rewind = 1; rd_en = 1; rd_req = 1;
            cyc();
            rd_rewind = 0; rd_en = 0; rd_req = 0;
            chk(rd_ack, 0, "R9 rewind wins over read");
            chk(empty, 0, "R9 block back");
            for (int i = 0; i < 4; i++) rd_one(W'(200 + i), "R9 replay");
            chk(empty, 1, "R9 replay done");
        end
        rd_keep = 0;
        repeat (8) cyc();
        chk(afull, 0, "R9 released after keep drop");
        rd_rewind = 1;
        cyc();
        rd_rewind = 0;
        chk(empty, 1, "R9 rewind ignored without keep");
        rd_en = 1; rd_req = 1;
        cyc();
        rd_en = 0; rd_req = 0;
        chk(rd_ack, 0, "R9 nothing to replay");
    endtask

    initial begin
        repeat (2) cyc();
        t_reset();
        t_defaults();
        t_enreq();
        t_latency();
        t_full();
        t_retx();
        done = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end
endmodule